// File: doc/BRIEF.md
# Flash Block RAM Overlay Remapper

This block lets code that would run from on-chip flash be patched in internal RAM during development. A small control register holds an overlay-enable bit and a two-bit block number. While the overlay is live, any CPU access to the chosen 1 KB flash block is steered onto a fixed 1 KB window of internal RAM. The low ten address bits are kept, so the RAM copy of the block lines up byte for byte with the flash it replaces.

The register is usable only in the operating modes that have internal flash. In every other mode it reads as zero and ignores writes. In one of the flash modes (mode 6) the overlay is not supported: a value written there is stored and reads back, but it never redirects an access and never protects flash. A reset or a hardware standby request clears the register. Software standby has no clear path, so the register keeps its value through it. Redirection also needs the system-level RAM enable. Flash write protection follows the overlay-enable bit alone.

Address translation is combinational from the current register contents and the presented address. Register writes land on the next clock edge.

Top module: `ram_overlay_remap`

## Requirements
- R1: Register bit 0 always reads as 1, and writing it has no effect.
- R2: With the enable bit (register bit 3) at 0, no access is redirected, for every block-select value.
- R3: With enable 1, in mode 5 or 7, and with RAM enable high, an access whose address bits 23:10 equal the select value (register bits 2:1; block n covers 0x400*n to 0x400*n+0x3FF) leaves as 0xFFF000 plus address bits 9:0, with ram_sel high and flash_sel low.
- R4: Every access that is not redirected leaves with its address unchanged.
- R5: With RAM enable low, no access is redirected, whatever the register holds.
- R6: flash_protect is high exactly when the stored enable bit is 1 and the mode is 5 or 7.
- R7: In mode 6, register writes are stored and read back, but nothing is redirected and flash_protect stays low.
- R8: In modes outside 5–7, register bits 3:1 read as 0 and writes leave the stored value unchanged.
- R9: A register write appears on the read port after the next rising clock edge, not before it.
- R10: Reset and hw_standby both clear the enable and select bits. hw_standby takes priority over a write in the same cycle.
- R11: A pass-through access asserts flash_sel when its address is at or below 0x01FFFF, and asserts ram_sel when its address is between 0xFFEF20 and 0xFFFF1F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_standby | input | 1 | Hardware standby request; clears the register |
| mode | input | 3 | Operating mode number |
| ram_en | input | 1 | System RAM enable |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 4 | Register write data |
| cfg_rdata | output | 4 | Register read data |
| acc_addr | input | 24 | CPU access address |
| xlat_addr | output | 24 | Translated address |
| ram_sel | output | 1 | Internal RAM selected |
| flash_sel | output | 1 | Flash selected |
| flash_protect | output | 1 | Flash program/erase blocked |

## Verification
Random addresses are drawn in four groups:
- the first 4 KB, where all four blocks live;
- addresses around the block edges (0x3FF/0x400 and so on);
- the internal RAM range;
- the full 24-bit space.

Each group is paired with random modes, random RAM enable and random register writes. The block-edge addresses show whether the decode uses the right address bits. Wrong modes and RAM enable low separate redirection from pass-through.

Directed sequences then cover four cases:
- Sweeping all four select values with enable low tells the enable gate apart from the select decode.
- Mode 6 shows that a stored value can be read back while having no effect.
- Writing in mode 4 and then switching to mode 5 shows whether writes are really dropped or only masked on read.
- Raising hw_standby together with a write shows which of the two wins.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    parameter int OVL_SEL_W   = 2;
    parameter int OVL_NUM_BLK = 1 << OVL_SEL_W;

    typedef struct packed {
        logic                 en;
        logic [OVL_SEL_W-1:0] sel;
    } ovl_cfg_t;

    typedef struct packed {
        ovl_cfg_t cfg;
    } ovl_state_t;
endpackage

// File: rtl/ovl_cfg_reg.sv
module ovl_cfg_reg
    import ovl_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_standby,
    input  logic              mode_ok,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ovl_cfg_t          cfg
);
    localparam int EN_BIT = DATA_W - 1;

    ovl_state_t state_d, state_q;
    logic       unused_wbit;

    assign unused_wbit = wdata[0];

    always_comb begin
        state_d = state_q;
        if (hw_standby) begin
            state_d.cfg = '0;
        end else if (we && mode_ok) begin
            state_d.cfg.en  = wdata[EN_BIT];
            state_d.cfg.sel = wdata[EN_BIT-1:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cfg = state_q.cfg;

    always_comb begin
        rdata = '0;
        if (mode_ok) begin
            rdata[EN_BIT]       = state_q.cfg.en;
            rdata[EN_BIT-1:1]   = state_q.cfg.sel;
        end
        rdata[0] = 1'b1;
    end
endmodule

// File: rtl/ovl_blk_match.sv
module ovl_blk_match
    import ovl_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int BLK_BITS = 10
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [OVL_SEL_W-1:0] sel,
    output logic                 hit
);
    localparam int HI_W = ADDR_W - BLK_BITS;

    logic [OVL_NUM_BLK-1:0] blk_hit;

    for (genvar i = 0; i < OVL_NUM_BLK; i++) begin : g_blk
        assign blk_hit[i] = (addr[ADDR_W-1:BLK_BITS] == HI_W'(i));
    end

    always_comb begin
        hit = blk_hit[sel];
    end
endmodule

// File: rtl/ovl_xlat.sv
module ovl_xlat #(
    parameter int              ADDR_W   = 24,
    parameter int              BLK_BITS = 10,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'hFFF000,
    parameter logic [ADDR_W-1:0] RAM_LO   = 24'hFFEF20,
    parameter logic [ADDR_W-1:0] RAM_HI   = 24'hFFFF1F,
    parameter logic [ADDR_W-1:0] FLASH_HI = 24'h01FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              redirect,
    output logic [ADDR_W-1:0] xaddr,
    output logic              ram_sel,
    output logic              flash_sel
);
    logic in_ram;
    logic in_flash;

    always_comb begin
        in_ram   = (addr >= RAM_LO) && (addr <= RAM_HI);
        in_flash = (addr <= FLASH_HI);
        if (redirect) begin
            xaddr     = {WIN_BASE[ADDR_W-1:BLK_BITS], addr[BLK_BITS-1:0]};
            ram_sel   = 1'b1;
            flash_sel = 1'b0;
        end else begin
            xaddr     = addr;
            ram_sel   = in_ram;
            flash_sel = in_flash;
        end
    end
endmodule

// File: rtl/ram_overlay_remap.sv
module ram_overlay_remap
    import ovl_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int BLK_BITS = 10,
    parameter int MODE_W   = 3,
    parameter int DATA_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_standby,
    input  logic [MODE_W-1:0] mode,
    input  logic              ram_en,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] xlat_addr,
    output logic              ram_sel,
    output logic              flash_sel,
    output logic              flash_protect
);
    localparam logic [MODE_W-1:0] MODE_LO   = MODE_W'(5);
    localparam logic [MODE_W-1:0] MODE_HI   = MODE_W'(7);
    localparam logic [MODE_W-1:0] MODE_NOEM = MODE_W'(6);

    logic     mode_ok;
    logic     emu_live;
    logic     blk_hit;
    logic     redirect;
    ovl_cfg_t cfg;

    always_comb begin
        mode_ok  = (mode >= MODE_LO) && (mode <= MODE_HI);
        emu_live = mode_ok && (mode != MODE_NOEM);
    end

    ovl_cfg_reg #(.DATA_W(DATA_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_standby (hw_standby),
        .mode_ok    (mode_ok),
        .we         (cfg_we),
        .wdata      (cfg_wdata),
        .rdata      (cfg_rdata),
        .cfg        (cfg)
    );

    ovl_blk_match #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_match (
        .addr (acc_addr),
        .sel  (cfg.sel),
        .hit  (blk_hit)
    );

    always_comb begin
        flash_protect = cfg.en && emu_live;
        redirect      = flash_protect && ram_en && blk_hit;
    end

    ovl_xlat #(.ADDR_W(ADDR_W), .BLK_BITS(BLK_BITS)) u_xlat (
        .addr      (acc_addr),
        .redirect  (redirect),
        .xaddr     (xlat_addr),
        .ram_sel   (ram_sel),
        .flash_sel (flash_sel)
    );
endmodule

// File: rtl/ovl_chk.sv
module ovl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hw_standby,
    input logic [2:0]  mode,
    input logic        ram_en,
    input logic        cfg_we,
    input logic [3:0]  cfg_rdata,
    input logic [23:0] acc_addr,
    input logic [23:0] xlat_addr,
    input logic        ram_sel,
    input logic        flash_sel,
    input logic        flash_protect
);
    // R1
    bit0_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[0] == 1'b1);

    // R3
    moved_to_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_addr != acc_addr) |-> (ram_sel && !flash_sel && xlat_addr[23:10] == 14'h3FFC));

    // R5
    no_ram_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en |-> (xlat_addr == acc_addr));

    // R7
    mode6_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6) |-> (!flash_protect && xlat_addr == acc_addr));

    // R8
    bad_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode < 3'd5) |-> (cfg_rdata[3:1] == 3'b000 && !flash_protect));

    // R10
    standby_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_standby |=> (cfg_rdata[3:1] == 3'b000 && !flash_protect));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !hw_standby) |=> ($stable(cfg_rdata) || !$stable(mode)));
endmodule

bind ram_overlay_remap ovl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .hw_standby    (hw_standby),
    .mode          (mode),
    .ram_en        (ram_en),
    .cfg_we        (cfg_we),
    .cfg_rdata     (cfg_rdata),
    .acc_addr      (acc_addr),
    .xlat_addr     (xlat_addr),
    .ram_sel       (ram_sel),
    .flash_sel     (flash_sel),
    .flash_protect (flash_protect)
);

// File: tb/tb_ram_overlay_remap.sv
module tb_ram_overlay_remap;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_standby = 1'b0;
    logic [2:0]  mode = 3'd5;
    logic        ram_en = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = 4'h0;
    logic [3:0]  cfg_rdata;
    logic [23:0] acc_addr = 24'h0;
    logic [23:0] xlat_addr;
    logic        ram_sel, flash_sel, flash_protect;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       m_en = 1'b0;
    logic [1:0] m_sel = 2'b00;

    always #10 clk = ~clk;

    ram_overlay_remap dut (
        .clk(clk), .rst_n(rst_n), .hw_standby(hw_standby), .mode(mode),
        .ram_en(ram_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_addr(acc_addr), .xlat_addr(xlat_addr),
        .ram_sel(ram_sel), .flash_sel(flash_sel), .flash_protect(flash_protect)
    );

    function automatic bit f_mode_ok(input logic [2:0] m);
        return (m >= 3'd5);
    endfunction

    function automatic bit f_live(input logic [2:0] m);
        return (m == 3'd5) || (m == 3'd7);
    endfunction

    function automatic bit f_redir(input logic [23:0] a);
        return m_en && f_live(mode) && ram_en && (a[23:10] == {12'h0, m_sel});
    endfunction

    function automatic logic [23:0] f_xlat(input logic [23:0] a);
        return f_redir(a) ? {14'h3FFC, a[9:0]} : a;
    endfunction

    function automatic logic [3:0] f_rdata();
        return f_mode_ok(mode) ? {m_en, m_sel, 1'b1} : 4'b0001;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        bit r;
        r = f_redir(acc_addr);
        chk(xlat_addr == f_xlat(acc_addr), r ? {tag, " R3 xlat"} : {tag, " R4 xlat"},
            32'(xlat_addr), 32'(f_xlat(acc_addr)));
        chk(ram_sel == (r || (acc_addr >= 24'hFFEF20 && acc_addr <= 24'hFFFF1F)),
            {tag, " R11 ram_sel"}, 32'(ram_sel), 32'(!ram_sel));
        chk(flash_sel == (!r && acc_addr <= 24'h01FFFF),
            {tag, " R11 flash_sel"}, 32'(flash_sel), 32'(!flash_sel));
        chk(flash_protect == (m_en && f_live(mode)), {tag, " R6 protect"},
            32'(flash_protect), 32'(m_en && f_live(mode)));
        chk(cfg_rdata == f_rdata(), {tag, " R8 rdata"}, 32'(cfg_rdata), 32'(f_rdata()));
    endtask

    // model update at the clock edge
    task automatic tick();
        @(posedge clk);
        if (hw_standby) begin
            m_en = 1'b0; m_sel = 2'b00;
        end else if (cfg_we && f_mode_ok(mode)) begin
            m_en = cfg_wdata[3]; m_sel = cfg_wdata[2:1];
        end
        #1;
        cfg_we = 1'b0;
        hw_standby = 1'b0;
    endtask

    task automatic wr(input logic [3:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        tick();
    endtask

    task automatic probe(input logic [23:0] a, input string tag);
        @(negedge clk);
        acc_addr = a;
        #1;
        check_outputs(tag);
    endtask

    function automatic logic [23:0] rand_addr();
        case ($urandom % 4)
            0: return {12'h000, 12'($urandom)};
            1: return 24'hFFEF00 + 24'($urandom % 24'h1100);
            2: return {12'h000, 2'($urandom), 10'h3FF} + 24'($urandom % 2);
            default: return 24'($urandom);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk(cfg_rdata == 4'b0001, "R10 reset rdata", 32'(cfg_rdata), 32'h1);
        rst_n = 1'b1;

        // R2 enable low, every select
        mode = 3'd5; ram_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            wr({1'b0, 2'(s), 1'b0});
            probe(24'(s * 1024 + 5), "R2 en0");
        end

        // R3 each block, edges
        for (int s = 0; s < 4; s++) begin
            wr({1'b1, 2'(s), 1'b0});
            probe(24'(s * 1024), "R3 lo");
            probe(24'(s * 1024 + 1023), "R3 hi");
            chk(xlat_addr == 24'hFFF3FF, "R3 top", 32'(xlat_addr), 32'hFFF3FF);
            probe(24'(((s + 1) % 4) * 1024), "R4 other");
        end

        // R1 bit 0 write ignored
        wr(4'b0000);
        chk(cfg_rdata[0] == 1'b1, "R1 bit0", 32'(cfg_rdata), 32'h1);

        // R9 write visible only after edge
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 4'b1101;
        #1;
        chk(cfg_rdata == 4'b0001, "R9 before edge", 32'(cfg_rdata), 32'h1);
        tick();
        chk(cfg_rdata == 4'b1101, "R9 after edge", 32'(cfg_rdata), 32'hD);

        // R5 ram enable low
        ram_en = 1'b0;
        probe(24'h000A10, "R5 ramoff");
        chk(xlat_addr == 24'h000A10, "R5 no move", 32'(xlat_addr), 32'hA10);
        ram_en = 1'b1;

        // R7 mode 6 stores but stays quiet
        mode = 3'd6;
        wr(4'b1011);
        probe(24'h000410, "R7 mode6");
        chk(cfg_rdata == 4'b1011 && !flash_protect && xlat_addr == 24'h000410,
            "R7 stored/quiet", 32'({cfg_rdata, 3'b0, flash_protect}), 32'hB0);

        // R8 write ignored in mode 4
        wr(4'b0000);
        mode = 3'd4;
        wr(4'b1111);
        probe(24'h000C00, "R8 mode4");
        mode = 3'd5;
        probe(24'h000C00, "R8 back5");
        chk(cfg_rdata == 4'b0001, "R8 write dropped", 32'(cfg_rdata), 32'h1);

        // R10 standby beats write
        wr(4'b1111);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 4'b1011; hw_standby = 1'b1;
        tick();
        chk(cfg_rdata == 4'b0001 && !flash_protect, "R10 standby",
            32'(cfg_rdata), 32'h1);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            mode       = 3'($urandom % 8);
            ram_en     = ($urandom % 4) != 0;
            cfg_we     = ($urandom % 3) == 0;
            cfg_wdata  = 4'($urandom);
            hw_standby = ($urandom % 40) == 0;
            acc_addr   = rand_addr();
            #1;
            check_outputs("rand");
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule